// File: doc/BRIEF.md
# Address-Masked GPIO Port

An 8-pin general-purpose I/O port behind a small memory-mapped register interface. In data accesses the byte address is itself the bit mask. Address bits 9 down to 2 choose which pins a single write may change, and which pins a single read returns. Software can therefore set some pins and clear others in one store. It can also sample a subset of pins without a separate AND operation.

The port has no separate output holding register. While a pin is an input, its output latch follows the synchronised pad level. When the pin is switched to output, it starts by driving the level it last saw, so the switch causes no glitch. A data write made after the switch then sets the driven level. Each pin has three control bits: a direction bit, a digital-enable bit and an alternate-function bit. The alternate-function bit hands the pin's drive to a peripheral-side input.

Top module: `gmp_port`

## Requirements
- R1: After reset, the direction, alternate and digital-enable registers read 0, every `pin_oe` bit is 0 and `bus_rdata` is 0.
- R2: A write with `bus_addr[11:10]==0` updates the output latch only for output pins whose mask bit `bus_addr[9:2]` is 1. All other output pins keep their driven value.
- R3: A read with `bus_addr[11:10]==0` returns 0 on every pin whose mask bit is 0, and the pin level on each masked pin. `bus_rdata[31:8]` is always 0.
- R4: Offset 0x3FC (mask 0xFF) writes and reads all eight pins at once.
- R5: While a pin is an input (direction bit 0), data writes to it have no effect, and its output value follows its synchronised input, one cycle behind.
- R6: A pin switched from input to output drives its last sampled input level. A later masked data write changes that level.
- R7: A pin whose digital-enable bit is 0 reads as 0 and has `pin_oe` forced to 0.
- R8: A pin whose alternate bit is 1 takes `pin_out` from `alt_out` and `pin_oe` from `alt_oe`, gated by its digital-enable bit.
- R9: `pin_in` passes through two flops. A change is seen by a read that is captured at the third clock edge after the change, and not earlier.
- R10: The control registers sit at offset 0x400 (direction), 0x404 (alternate select) and 0x408 (digital enable). Each takes `bus_wdata[7:0]` on a write and returns its value on a read one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| alt_out | input | 8 | Peripheral-side output values |
| alt_oe | input | 8 | Peripheral-side output enables |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
Masked writes are tried with complementary nibble masks and with the full 0xFF mask. Each write carries a value that differs from the current state in both the masked and unmasked bits, so a write that ignores the mask shows up in the unmasked bits. Reads use a mask that straddles both nibbles, which separates "masked bits zeroed" from "whole byte returned". The input-to-output switch is tried with a mixed high/low input pattern, and after a full-mask data write that should be ignored. This tells a design that tracks the pad apart from one that keeps a holding register. The synchroniser check reads on three successive edges to pin down the two-flop latency exactly.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
   localparam int unsigned PIN_W    = 8;
   localparam int unsigned ADDR_W   = 12;
   localparam int unsigned BUS_W    = 32;
   localparam logic [ADDR_W-1:0] OFS_DIR = 12'h400;
   localparam logic [ADDR_W-1:0] OFS_ALT = 12'h404;
   localparam logic [ADDR_W-1:0] OFS_DEN = 12'h408;

   typedef struct packed {
      logic [PIN_W-1:0] dir;
      logic [PIN_W-1:0] alt;
      logic [PIN_W-1:0] den;
   } gmp_ctrl_t;
endpackage

// File: rtl/gmp_sync.sv
module gmp_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
   import gmp_pkg::*;
#(
   parameter int unsigned NPIN  = 8,
   parameter int unsigned AW    = 12,
   parameter int unsigned DW    = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_valid,
   input  logic            bus_write,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NPIN-1:0] pad_sync,
   output gmp_ctrl_t       ctrl,
   output logic [NPIN-1:0] latch_q
);
   localparam int unsigned MASK_LO = 2;
   localparam int unsigned MASK_HI = MASK_LO + NPIN - 1;
   localparam int unsigned WIN_BIT = MASK_HI + 1;

   logic            in_window;
   logic [NPIN-1:0] acc_mask;
   logic            wr_data, wr_dir, wr_alt, wr_den, rd_any;
   logic [NPIN-1:0] level;
   logic [NPIN-1:0] rd_byte;

   assign in_window = (bus_addr[AW-1:WIN_BIT] == '0);
   assign acc_mask  = bus_addr[MASK_HI:MASK_LO];
   assign wr_data   = bus_valid && bus_write && in_window;
   assign wr_dir    = bus_valid && bus_write && (bus_addr == OFS_DIR);
   assign wr_alt    = bus_valid && bus_write && (bus_addr == OFS_ALT);
   assign wr_den    = bus_valid && bus_write && (bus_addr == OFS_DEN);
   assign rd_any    = bus_valid && !bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_dir) ctrl.dir <= bus_wdata[NPIN-1:0];
         if (wr_alt) ctrl.alt <= bus_wdata[NPIN-1:0];
         if (wr_den) ctrl.den <= bus_wdata[NPIN-1:0];
      end
   end

   for (genvar b = 0; b < int'(NPIN); b++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              latch_q[b] <= 1'b0;
         else if (!ctrl.dir[b])   latch_q[b] <= pad_sync[b];
         else if (wr_data && acc_mask[b]) latch_q[b] <= bus_wdata[b];
      end
      assign level[b] = (ctrl.dir[b] && !ctrl.alt[b]) ? latch_q[b] : pad_sync[b];
   end

   always_comb begin
      rd_byte = '0;
      if (in_window)                rd_byte = level & acc_mask & ctrl.den;
      else if (bus_addr == OFS_DIR) rd_byte = ctrl.dir;
      else if (bus_addr == OFS_ALT) rd_byte = ctrl.alt;
      else if (bus_addr == OFS_DEN) rd_byte = ctrl.den;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_any) bus_rdata <= {{(DW-NPIN){1'b0}}, rd_byte};
   end
endmodule

// File: rtl/gmp_pinmux.sv
module gmp_pinmux
   import gmp_pkg::*;
#(
   parameter int unsigned NPIN = 8
) (
   input  gmp_ctrl_t       ctrl,
   input  logic [NPIN-1:0] latch_q,
   input  logic [NPIN-1:0] alt_out,
   input  logic [NPIN-1:0] alt_oe,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe
);
   for (genvar b = 0; b < int'(NPIN); b++) begin : g_pin
      assign pin_out[b] = ctrl.alt[b] ? alt_out[b] : latch_q[b];
      assign pin_oe[b]  = ctrl.den[b] && (ctrl.alt[b] ? alt_oe[b] : ctrl.dir[b]);
   end
endmodule

// File: rtl/gmp_port.sv
module gmp_port
   import gmp_pkg::*;
#(
   parameter int unsigned NPIN        = PIN_W,
   parameter int unsigned AW          = ADDR_W,
   parameter int unsigned DW          = BUS_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_valid,
   input  logic            bus_write,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NPIN-1:0] pin_in,
   input  logic [NPIN-1:0] alt_out,
   input  logic [NPIN-1:0] alt_oe,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe
);
   if (NPIN != PIN_W) begin : g_bad_npin
      $error("gmp_port: NPIN must equal the 8-bit address mask width");
   end
   if (AW != ADDR_W) begin : g_bad_aw
      $error("gmp_port: AW must be 12 for the 4 KB window");
   end
   if (DW < NPIN) begin : g_bad_dw
      $error("gmp_port: DW must cover all pins");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gmp_port: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0] pad_sync;
   logic [NPIN-1:0] latch_q;
   gmp_ctrl_t       ctrl;

   gmp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
   );

   gmp_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_sync(pad_sync), .ctrl(ctrl), .latch_q(latch_q)
   );

   gmp_pinmux #(.NPIN(NPIN)) u_mux (
      .ctrl(ctrl), .latch_q(latch_q),
      .alt_out(alt_out), .alt_oe(alt_oe),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );
endmodule

// File: rtl/gmp_port_chk.sv
module gmp_port_chk
   import gmp_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_valid,
   input logic        bus_write,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_rdata,
   input logic [7:0]  alt_out,
   input logic [7:0]  pin_out,
   input logic [7:0]  pin_oe,
   input logic [7:0]  pad_sync,
   input gmp_ctrl_t   ctrl
);
   // R1: first cycle out of reset has no pin driven
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pin_oe == 8'h00 && bus_rdata == 32'h0));

   // R3: upper read bits never set
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:8] == 24'h0);

   // R5: input pins echo the synchronised pad one cycle later
   a_r5_input_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ $past(pad_sync)) & ~$past(ctrl.dir) & ~ctrl.alt) == 8'h00);

   // R2: driven GPIO value changes only after a data-window write
   a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ $past(pin_out)) & ctrl.dir & $past(ctrl.dir)
         & ~ctrl.alt & ~$past(ctrl.alt)) != 8'h00)
      |-> $past(bus_valid && bus_write && bus_addr[11:10] == 2'b00));

   // R7: no output enable without digital enable
   a_r7_den_gates_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~ctrl.den) == 8'h00);

   // R8: alternate pins carry the peripheral value
   a_r8_alt_value: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ alt_out) & ctrl.alt) == 8'h00);
endmodule

bind gmp_port gmp_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .alt_out(alt_out),
   .pin_out(pin_out), .pin_oe(pin_oe), .pad_sync(pad_sync), .ctrl(ctrl)
);

// File: tb/tb_gmp_port.sv
module tb_gmp_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  alt_out = '0;
   logic [7:0]  alt_oe = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gmp_port dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 rdata", bus_rdata, 32'h0);
      check("R1 oe", {24'h0, pin_oe}, 32'h0);
      rd(12'h400, v); check("R1 dir", v, 32'h0);
      rd(12'h408, v); check("R1 den", v, 32'h0);
   endtask

   task automatic t_ctrl_readback();
      logic [31:0] v;
      wr(12'h404, 32'hFFFF_FF5A); rd(12'h404, v); check("R10 alt", v, 32'h5A);
      wr(12'h404, 32'h0);
      wr(12'h400, 32'h0000_00FF); rd(12'h400, v); check("R10 dir", v, 32'hFF);
      wr(12'h408, 32'h0000_00FF); rd(12'h408, v); check("R10 den", v, 32'hFF);
   endtask

   task automatic t_masked_write_read();
      logic [31:0] v;
      wr(12'h3FC, 32'h0);
      check("R4 full write", {24'h0, pin_out}, 32'h00);
      wr(12'h03C, 32'hFFFF_FFAB);
      check("R2 low mask", {24'h0, pin_out}, 32'h0B);
      wr(12'h3C0, 32'h0000_005C);
      check("R2 high mask", {24'h0, pin_out}, 32'h5B);
      rd(12'h0F0, v); check("R3 masked read", v, 32'h18);
      rd(12'h3FC, v); check("R4 full read", v, 32'h5B);
      check("R2 oe", {24'h0, pin_oe}, 32'hFF);
   endtask

   task automatic t_den();
      logic [31:0] v;
      wr(12'h408, 32'h0F);
      check("R7 oe gated", {24'h0, pin_oe}, 32'h0F);
      rd(12'h3FC, v); check("R7 read zero", v, 32'h0B);
      wr(12'h408, 32'hFF);
   endtask

   task automatic t_alt();
      wr(12'h400, 32'h0F);
      alt_out = 8'h3C; alt_oe = 8'hFF;
      wr(12'h404, 32'hF0);
      check("R8 value", {24'h0, pin_out}, {24'h0, 8'h30 | (pin_out & 8'h0F)});
      check("R8 oe", {24'h0, pin_oe}, 32'hFF);
      alt_oe = 8'h00; #1;
      check("R8 oe follow", {24'h0, pin_oe}, 32'h0F);
      wr(12'h408, 32'h0F); alt_oe = 8'hFF; #1;
      check("R8 den gate", {24'h0, pin_oe}, 32'h0F);
      wr(12'h408, 32'hFF); wr(12'h404, 32'h0); alt_oe = 8'h00;
   endtask

   task automatic t_input_switch();
      wr(12'h400, 32'h00);
      pin_in = 8'hA5; idle(4);
      check("R5 tracks input", {24'h0, pin_out}, 32'hA5);
      wr(12'h3FC, 32'hFF); idle(1);
      check("R5 write ignored", {24'h0, pin_out}, 32'hA5);
      wr(12'h400, 32'h0F);
      check("R6 keeps level", {24'h0, pin_out}, 32'hA5);
      check("R6 oe", {24'h0, pin_oe}, 32'h0F);
      pin_in = 8'h00; idle(4);
      check("R6 hold vs track", {24'h0, pin_out}, 32'h05);
      wr(12'h00C, 32'h02);
      check("R6 later write", {24'h0, pin_out}, 32'h06);
   endtask

   task automatic t_sync_latency();
      logic [31:0] v;
      wr(12'h400, 32'h00);
      pin_in = 8'h00; idle(4);
      pin_in = 8'hC3;
      rd(12'h3FC, v); check("R9 edge1", v, 32'h00);
      rd(12'h3FC, v); check("R9 edge2", v, 32'h00);
      rd(12'h3FC, v); check("R9 edge3", v, 32'hC3);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_ctrl_readback();
      t_masked_write_read();
      t_den();
      t_alt();
      t_input_switch();
      t_sync_latency();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule